// File: doc/BRIEF.md
# Parallel Receive Run-Length Monitor

This block sits on the parallel side of a serial receiver. Each word that arrives with its valid strobe first passes through two optional conditioning steps. One complements every bit, which corrects a swapped differential pair. The other mirrors the word end to end, which corrects a link that sends the most significant bit first. The conditioned word is registered and driven out. The same word is also scanned for runs of identical bits.

The scan starts at bit 0 and moves upward through the word. A run of ones or of zeros is tracked across word boundaries. When a run grows longer than the programmed limit, a sticky violation flag is raised. The flag stays high until the synchronous clear input or reset. The legal range of the limit follows from the word width W: the lowest value is W/2, and the highest is 16·W for 8- and 10-bit words and 32·W for 16- and 20-bit words. A limit outside that range is pulled to the nearest bound.

Top module: `rx_runlen_mon`

## Requirements
- R1: With `inv_en` high, every bit of an accepted word is complemented before it is reversed, scanned or driven out.
- R2: With `rev_en` high, output bit i takes the conditioned input bit W-1-i. When both enables are high, the output is the reversed complement.
- R3: `out_data` and `rlv` reflect an accepted word one clock edge after the edge at which `in_vld` is sampled high. Before that edge they keep their previous values.
- R4: While `in_vld` is low, `out_data`, the run state and `rlv` hold their values, apart from a clear. A run that is in progress continues with the next valid word.
- R5: Runs of ones and runs of zeros are both counted. Bits are taken from index 0 upward, and a run carries over from one accepted word into the next.
- R6: `rlv` is set by a word in which the run length becomes greater than the effective limit. A run exactly equal to the limit does not set it.
- R7: Once set, `rlv` stays high until `clr`. If `clr` arrives together with a word that violates, `rlv` ends up set.
- R8: A `thresh` value below W/2 acts as W/2. A value above the width's maximum (160 for W=10) acts as that maximum.
- R9: Active-low reset clears `out_data` and `rlv` to 0 and discards any run in progress, so the first bit after reset starts a run of length 1.
- R10: The run counter saturates and does not wrap. A run of any length keeps its count above every legal limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of the violation flag |
| in_vld | input | 1 | Input word valid |
| in_data | input | W | Received parallel word |
| thresh | input | CNT_W | Maximum allowed run length, clamped to the legal range |
| inv_en | input | 1 | Enables complementing every bit of the word |
| rev_en | input | 1 | Enables mirroring the bit order of the word |
| out_data | output | W | Registered conditioned word |
| rlv | output | 1 | Sticky run-length violation flag |

## Verification
Some properties are checked on every cycle:
- the complement-only and mirror-only transforms at the output;
- holding of the word and the flag while idle;
- stickiness of the flag;
- clearing of the flag when no word arrives.

Other behaviour needs the bench's scenarios, because it depends on accumulated run history:
- exact run counting across word boundaries and idle gaps;
- the boundary between a limit and one bit more;
- clamping of the threshold at both ends;
- counter saturation on very long runs;
- the discarding of the run at reset.

// File: rtl/rlm_pkg.sv
// Package: width-dependent run limits shared by the monitor and its checker.
// Assumes W is one of 8, 10, 16 or 20.
package rlm_pkg;
    // Smallest legal run limit for word width w.
    function automatic int run_min(input int w);
        return w / 2;
    endfunction

    // Largest legal run limit for word width w.
    function automatic int run_max(input int w);
        return (w <= 10) ? 16 * w : 32 * w;
    endfunction
endpackage

// File: rtl/rlm_cond.sv
// Word conditioner: optional complement of every bit, followed by an optional
// end-to-end mirror of the bit order. Purely combinational.
// Assumes the enables are stable for the cycle the word is accepted.
module rlm_cond #(
    parameter int W = 10
) (
    input  logic [W-1:0] din,
    input  logic         inv_en,
    input  logic         rev_en,
    output logic [W-1:0] dout
);
    logic [W-1:0] pol;
    logic [W-1:0] mir;

    // Complement the word when polarity correction is enabled.
    always_comb pol = din ^ {W{inv_en}};

    // Mirror the bit order, one wire per bit.
    for (genvar i = 0; i < W; i++) begin : g_mir
        assign mir[i] = pol[W-1-i];
    end

    // Select the mirrored or the straight word.
    always_comb dout = rev_en ? mir : pol;
endmodule

// File: rtl/rlm_thr_clamp.sv
// Threshold clamp: pulls the programmed limit into [LO_V, HI_V].
// Assumes HI_V fits in TW bits.
module rlm_thr_clamp #(
    parameter int TW   = 9,
    parameter int LO_V = 5,
    parameter int HI_V = 160
) (
    input  logic [TW-1:0] thr_in,
    output logic [TW-1:0] thr_out
);
    localparam logic [TW-1:0] LO = TW'(LO_V);
    localparam logic [TW-1:0] HI = TW'(HI_V);

    // Clamp to the nearest legal bound.
    always_comb begin
        if (thr_in < LO)      thr_out = LO;
        else if (thr_in > HI) thr_out = HI;
        else                  thr_out = thr_in;
    end
endmodule

// File: rtl/rlm_run_scan.sv
// Run scanner: walks the word from bit 0 upward, continuing the run held in
// prev_bit/run_cnt. A zero count means that no run is in progress. Reports the
// updated run state and whether any run in the word went beyond the limit.
// Assumes the limit is below the saturation value of the counter.
module rlm_run_scan #(
    parameter int W  = 10,
    parameter int CW = 9
) (
    input  logic [W-1:0]  word,
    input  logic          prev_bit,
    input  logic [CW-1:0] run_cnt,
    input  logic [CW-1:0] limit,
    output logic          nxt_bit,
    output logic [CW-1:0] nxt_cnt,
    output logic          over
);
    localparam logic [CW-1:0] SAT = {CW{1'b1}};

    // Bit-serial scan unrolled across the word.
    always_comb begin
        logic [CW-1:0] c;
        logic          p;
        c    = run_cnt;
        p    = prev_bit;
        over = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (c != '0 && word[i] == p) begin
                if (c != SAT) c = c + 1'b1;
            end else begin
                c = CW'(1);
            end
            p = word[i];
            if (c > limit) over = 1'b1;
        end
        nxt_bit = p;
        nxt_cnt = c;
    end
endmodule

// File: rtl/rx_runlen_mon.sv
// Parallel receive run-length monitor. Conditions each valid word (polarity,
// bit order), registers it out, and raises a sticky flag when a run of equal
// bits exceeds the clamped limit. Runs span words; idle cycles hold state.
// Assumes W is 8, 10, 16 or 20. Reset is synchronous and active low.
module rx_runlen_mon #(
    parameter int W = 10,
    localparam int RL_MIN = rlm_pkg::run_min(W),
    localparam int RL_MAX = rlm_pkg::run_max(W),
    localparam int CNT_W  = $clog2(RL_MAX) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             in_vld,
    input  logic [W-1:0]     in_data,
    input  logic [CNT_W-1:0] thresh,
    input  logic             inv_en,
    input  logic             rev_en,
    output logic [W-1:0]     out_data,
    output logic             rlv
);
    logic [W-1:0]     cond_w;
    logic [CNT_W-1:0] lim;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             bit_q, bit_d;
    logic             over;
    logic [W-1:0]     out_q;
    logic             rlv_q;

    rlm_cond #(.W(W)) u_cond (
        .din(in_data), .inv_en(inv_en), .rev_en(rev_en), .dout(cond_w)
    );

    rlm_thr_clamp #(.TW(CNT_W), .LO_V(RL_MIN), .HI_V(RL_MAX)) u_clamp (
        .thr_in(thresh), .thr_out(lim)
    );

    rlm_run_scan #(.W(W), .CW(CNT_W)) u_scan (
        .word(cond_w), .prev_bit(bit_q), .run_cnt(cnt_q), .limit(lim),
        .nxt_bit(bit_d), .nxt_cnt(cnt_d), .over(over)
    );

    // Register run state and output word on accepted words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            bit_q <= 1'b0;
            out_q <= '0;
        end else if (in_vld) begin
            cnt_q <= cnt_d;
            bit_q <= bit_d;
            out_q <= cond_w;
        end
    end

    // Sticky violation flag; a new violation wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) rlv_q <= 1'b0;
        else        rlv_q <= (rlv_q & ~clr) | (in_vld & over);
    end

    assign out_data = out_q;
    assign rlv      = rlv_q;
endmodule

// File: rtl/rlm_chk.sv
// Checker for rx_runlen_mon: per-cycle properties on conditioning, idle
// holding and flag stickiness. Bound to every instance of the monitor.
module rlm_chk #(
    parameter int W = 10,
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             in_vld,
    input logic [W-1:0]     in_data,
    input logic [CNT_W-1:0] thresh,
    input logic             inv_en,
    input logic             rev_en,
    input logic [W-1:0]     out_data,
    input logic             rlv
);
    logic [W-1:0] mirrored;

    // Independent mirror of the raw input.
    always_comb begin
        for (int i = 0; i < W; i++) mirrored[i] = in_data[W-1-i];
    end

    p_inv_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld && inv_en && !rev_en |=> out_data == ~$past(in_data));

    p_rev_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld && rev_en && !inv_en |=> out_data == $past(mirrored));

    p_hold_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable(out_data));

    p_hold_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld && !clr |=> $stable(rlv));

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rlv && !clr |=> rlv);

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !in_vld |=> !rlv);
endmodule

bind rx_runlen_mon rlm_chk #(.W(W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_vld(in_vld), .in_data(in_data),
    .thresh(thresh), .inv_en(inv_en), .rev_en(rev_en),
    .out_data(out_data), .rlv(rlv)
);

// File: tb/rx_runlen_mon_tb.sv
module rx_runlen_mon_tb;
    localparam int W  = 10;
    localparam int TW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          in_vld = 1'b0;
    logic [W-1:0]  in_data = '0;
    logic [TW-1:0] thresh = '0;
    logic          inv_en = 1'b0;
    logic          rev_en = 1'b0;
    logic [W-1:0]  out_data;
    logic          rlv;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    rx_runlen_mon #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_vld(in_vld),
        .in_data(in_data), .thresh(thresh), .inv_en(inv_en),
        .rev_en(rev_en), .out_data(out_data), .rlv(rlv)
    );

    always #5 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            $display("FAIL watchdog: actual=%0d cycles expected<=20000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad + 1);
            $finish;
        end
    end

    typedef struct packed {
        logic          vld;
        logic          cl;
        logic          inv;
        logic          rev;
        logic [TW-1:0] thr;
        logic [W-1:0]  din;
        logic [W-1:0]  dout;
        logic          flag;
    } vec_t;

    // vld clr inv rev thr din dout rlv
    localparam vec_t VEC [12] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 9'd20, 10'h155, 10'h155, 1'b0}, // R5 alternating
        '{1'b1, 1'b0, 1'b0, 1'b0, 9'd20, 10'h000, 10'h000, 1'b0}, // R5 zero run 11
        '{1'b1, 1'b0, 1'b0, 1'b0, 9'd20, 10'h000, 10'h000, 1'b1}, // R6 run 21 > 20
        '{1'b0, 1'b1, 1'b0, 1'b0, 9'd20, 10'h000, 10'h000, 1'b0}, // R7 clear
        '{1'b0, 1'b0, 1'b0, 1'b0, 9'd20, 10'h3FF, 10'h000, 1'b0}, // R4 idle ignored
        '{1'b1, 1'b0, 1'b1, 1'b0, 9'd20, 10'h3FF, 10'h000, 1'b1}, // R1 R4 run 31
        '{1'b1, 1'b1, 1'b0, 1'b0, 9'd20, 10'h3FF, 10'h3FF, 1'b0}, // R7 clear, ones 10
        '{1'b1, 1'b0, 1'b0, 1'b1, 9'd20, 10'h001, 10'h200, 1'b0}, // R2 mirror
        '{1'b1, 1'b0, 1'b1, 1'b1, 9'd20, 10'h001, 10'h1FF, 1'b0}, // R2 both
        '{1'b1, 1'b0, 1'b0, 1'b0, 9'd0,  10'h01F, 10'h01F, 1'b0}, // R8 low clamp 5
        '{1'b1, 1'b0, 1'b0, 1'b0, 9'd0,  10'h3E0, 10'h3E0, 1'b1}, // R8 zero run 10 > 5
        '{1'b0, 1'b1, 1'b0, 1'b0, 9'd0,  10'h3E0, 10'h3E0, 1'b0}  // R7 clear idle
    };

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at the falling edge, sample just after the next rising edge.
    task automatic apply(input logic v, input logic c, input logic iv, input logic rv,
                         input logic [TW-1:0] t, input logic [W-1:0] d);
        @(negedge clk);
        in_vld = v; clr = c; inv_en = iv; rev_en = rv; thresh = t; in_data = d;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_vld = 1'b0; clr = 1'b0;
        @(posedge clk);
        #1;
        check("R9 out_data after reset", out_data, '0);
        check("R9 rlv after reset", W'(rlv), '0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        // Reset state
        repeat (2) @(posedge clk);
        do_reset();

        // Vector table
        for (int k = 0; k < 12; k++) begin
            apply(VEC[k].vld, VEC[k].cl, VEC[k].inv, VEC[k].rev, VEC[k].thr, VEC[k].din);
            check($sformatf("R1/R2/R3/R5 vector %0d out_data", k), out_data, VEC[k].dout);
            check($sformatf("R4/R6/R7/R8 vector %0d rlv", k), W'(rlv), W'(VEC[k].flag));
        end

        // R3: output unchanged before the capturing edge
        @(negedge clk);
        in_vld = 1'b1; clr = 1'b0; inv_en = 1'b0; rev_en = 1'b0; in_data = 10'h155;
        #1;
        check("R3 out_data before edge", out_data, 10'h3E0);
        @(posedge clk);
        #1;
        check("R3 out_data after edge", out_data, 10'h155);

        // R8 high clamp and R6 boundary: 511 acts as 160
        do_reset();
        for (int k = 0; k < 16; k++) apply(1'b1, 1'b0, 1'b0, 1'b0, 9'd511, 10'h3FF);
        check("R6 run of 160 equals limit", W'(rlv), '0);
        apply(1'b1, 1'b0, 1'b0, 1'b0, 9'd511, 10'h3FF);
        check("R8 run of 170 over clamped 160", W'(rlv), 1);

        // R10: 600 bits of ones, then clear, then one more word
        for (int k = 0; k < 43; k++) apply(1'b1, 1'b0, 1'b0, 1'b0, 9'd511, 10'h3FF);
        apply(1'b0, 1'b1, 1'b0, 1'b0, 9'd511, 10'h3FF);
        check("R7 clear after long run", W'(rlv), '0);
        apply(1'b1, 1'b0, 1'b0, 1'b0, 9'd511, 10'h3FF);
        check("R10 saturated run still over limit", W'(rlv), 1);

        // R9: reset discards the saturated run
        do_reset();
        apply(1'b1, 1'b0, 1'b0, 1'b0, 9'd10, 10'h3FF);
        check("R9 run restarts after reset", W'(rlv), '0);
        apply(1'b1, 1'b0, 1'b0, 1'b0, 9'd10, 10'h3FF);
        check("R5 run of 20 across words", W'(rlv), 1);

        // R7: a clear together with a violating word leaves the flag set
        apply(1'b1, 1'b1, 1'b0, 1'b0, 9'd5, 10'h000);
        check("R7 violation wins over clear", W'(rlv), 1);

        @(negedge clk);
        in_vld = 1'b0; clr = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule